// File: doc/BRIEF.md
# Bit-serial truth-table processing element

This block is one cell of a single-bit SIMD array. Every cell receives the same broadcast instruction each clock. It combines two selected source bits with its carry flag through a programmable three-input, two-output logic function. The destination bit and the next carry both come from a 16-bit truth table carried in the instruction, so the block has no fixed opcode set: add, subtract, compare, select and plain logic are all just different table contents.

Each cell holds seven general flags (X, Y, Z, T, U, V, A), a carry flag F and a bit-addressed register file. It reads the one-bit outputs of its eight compass neighbours and presents one chosen flag back to them. Execution can be gated by the A flag, so the array can mask work per cell. Multi-bit arithmetic is built by a sequencer outside the block, issuing one instruction per bit from least significant upward and letting F carry between bits.

Top module: `pe_cell`

## Requirements
- R1: After reset, all eight flags and every register-file bit are 0.
- R2: For input index k = {i, j, F} (i most significant), the function bits [15-2k] and [14-2k] give the new F and the destination value d. Both take effect at the next rising clock edge.
- R3: Function code 16'h166B yields {new F, d} = i + j + F. A 4-bit add made of one such instruction per bit, least significant bit first, leaves the sum in place and the carry out in F.
- R4: The src_i codes are 0..7 for neighbour inputs N, NE, E, SE, S, SW, W, NW (nbr_in bits 0..7), 8..14 for X, Y, Z, T, U, V, A, and 15 for the register file. The src_j and dest codes are 0..6 for X..A and 7 for the register file.
- R5: The register file has a single address field, used for both reading and writing. A write changes only the addressed bit.
- R6: The outsel codes are 0..6 for X..A and 7 for F. nbr_out shows the selected current flag in the same cycle the instruction is presented, even while the cell reads a neighbour.
- R7: When cond bit 0 is 1, a cell with A=0 writes neither d (flag or register file) nor F. When cond bit 0 is 0, every cell executes whatever its A value.
- R8: A gated-off cell still drives nbr_out according to outsel.
- R9: Every executing instruction writes F with the function's carry output. Holding F takes a table whose carry column copies F.
- R10: The instruction word is, from the most significant bit down: function[39:24], cond[23:21], src_i[20:17], src_j[16:14], dest[13:11], outsel[10:8] and address[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 40 | Broadcast instruction word (CTL_W + address width) |
| nbr_in | input | 8 | Outputs of the eight neighbours, N at bit 0 clockwise to NW at bit 7 |
| nbr_out | output | 1 | Flag selected by outsel, seen by neighbours |

## Verification
The bench walks all eight truth-table rows with an irregular code. A design that reads the pairs in the wrong order, or swaps the carry and data bits, produces visibly wrong Z and F values. Several multi-bit additions include full carry chains and a final carry out. These catch a lost or misrouted carry and any shared-address write that disturbs the other operand's bits. Masked execution is checked on flags, on F and on the register file, with nbr_out observed in the same masked cycle. A design that leaks writes past A, or freezes the neighbour output when masked, fails there. A chained forward-F-while-reading-W test catches an output that lags by a cycle.

// File: rtl/pe_pkg.sv
package pe_pkg;
   localparam int NUM_IN    = 3;
   localparam int NUM_ROWS  = 1 << NUM_IN;
   localparam int FUNC_W    = 2 * NUM_ROWS;
   localparam int NUM_NBR   = 8;
   localparam int NUM_FLAGS = 7;
   localparam int COND_W    = 3;
   localparam int SRCI_W    = 4;
   localparam int LOC_W     = 3;
   localparam int CTL_W     = FUNC_W + COND_W + SRCI_W + 3 * LOC_W;

   // location code shared by src_j, dest and outsel (code 7: memory or F)
   typedef enum logic [LOC_W-1:0] {
      LOC_X, LOC_Y, LOC_Z, LOC_T, LOC_U, LOC_V, LOC_A, LOC_MEM
   } loc_e;

   localparam logic [FUNC_W-1:0] FN_ADC = 16'h166B;

   typedef struct packed {
      logic [FUNC_W-1:0] func;
      logic [COND_W-1:0] cond;
      logic [SRCI_W-1:0] src_i;
      loc_e              src_j;
      loc_e              dest;
      loc_e              outsel;
   } pe_ctl_t;
endpackage

// File: rtl/pe_decode.sv
module pe_decode
   import pe_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic [CTL_W+ADDR_W-1:0] instr,
   output pe_ctl_t                 ctl,
   output logic [ADDR_W-1:0]       addr,
   output logic                    i_from_nbr,
   output logic                    i_from_mem,
   output logic [2:0]              i_idx,
   output logic                    j_from_mem,
   output logic                    dst_mem,
   output logic [NUM_FLAGS-1:0]    dst_flag_oh,
   output logic                    gated
);
   // R10: control fields above, address below
   assign ctl  = pe_ctl_t'(instr[CTL_W+ADDR_W-1:ADDR_W]);
   assign addr = instr[ADDR_W-1:0];

   // R4: src_i upper bit splits neighbours from local storage
   assign i_from_nbr = ~ctl.src_i[SRCI_W-1];
   assign i_idx      = ctl.src_i[2:0];
   assign i_from_mem = ctl.src_i[SRCI_W-1] & (ctl.src_i[2:0] == 3'd7);
   assign j_from_mem = (ctl.src_j == LOC_MEM);
   assign dst_mem    = (ctl.dest == LOC_MEM);
   assign gated      = ctl.cond[0];

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dst
      assign dst_flag_oh[g] = (ctl.dest == loc_e'(g));
   end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
   import pe_pkg::*;
#(
   parameter int STYLE = 0   // 0: indexed mux, 1: one-hot AND-OR
)(
   input  logic [FUNC_W-1:0] func,
   input  logic              i_bit,
   input  logic              j_bit,
   input  logic              f_bit,
   output logic              d_bit,
   output logic              f_nxt
);
   logic [NUM_IN-1:0]   row;
   logic [NUM_ROWS-1:0] d_col;
   logic [NUM_ROWS-1:0] f_col;

   assign row = {i_bit, j_bit, f_bit};

   // R2: pair r counted from the top; upper bit is carry, lower is data
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_col
      assign f_col[r] = func[FUNC_W-1-2*r];
      assign d_col[r] = func[FUNC_W-2-2*r];
   end

   if (STYLE == 0) begin : g_mux
      assign d_bit = d_col[row];
      assign f_nxt = f_col[row];
   end else begin : g_sop
      logic [NUM_ROWS-1:0] hit;
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_hit
         assign hit[r] = (row == NUM_IN'(r));
      end
      assign d_bit = |(hit & d_col);
      assign f_nxt = |(hit & f_col);
   end

   initial begin
      if (STYLE != 0 && STYLE != 1) $error("pe_alu: STYLE must be 0 or 1");
   end

   always_comb begin
      p_adc_sum_r3: assert ((func != FN_ADC) ||
         ({f_nxt, d_bit} == ({1'b0, i_bit} + {1'b0, j_bit} + {1'b0, f_bit})));
   end
endmodule

// File: rtl/pe_regfile.sv
module pe_regfile #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              wdata,
   output logic              rdata
);
   logic [DEPTH-1:0] bits_q;
   logic             in_range;

   if (DEPTH == (1 << ADDR_W)) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_part
      assign in_range = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));
   end

   assign rdata = in_range ? bits_q[addr] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else if (we && in_range) bits_q[addr] <= wdata;
   end

   initial begin
      if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) $error("pe_regfile: DEPTH out of range");
   end

   p_rf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(bits_q));
   p_rf_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && in_range) |=> (bits_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/pe_cell.sv
module pe_cell
   import pe_pkg::*;
#(
   parameter  int MEM_DEPTH = 256,
   parameter  int ALU_STYLE = 0,
   localparam int ADDR_W    = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
   localparam int INSTR_W   = CTL_W + ADDR_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [NUM_NBR-1:0] nbr_in,
   output logic               nbr_out
);
   pe_ctl_t               ctl;
   logic [ADDR_W-1:0]     addr;
   logic                  i_from_nbr, i_from_mem, j_from_mem, dst_mem, gated;
   logic [2:0]            i_idx;
   logic [NUM_FLAGS-1:0]  dst_flag_oh;
   logic [NUM_FLAGS-1:0]  flag_q;
   logic                  f_q;
   logic [NUM_FLAGS:0]    flags8;
   logic                  rf_rd, i_bit, j_bit, alu_d, alu_f, cell_en;

   pe_decode #(.ADDR_W(ADDR_W)) u_dec (
      .instr(instr), .ctl(ctl), .addr(addr),
      .i_from_nbr(i_from_nbr), .i_from_mem(i_from_mem), .i_idx(i_idx),
      .j_from_mem(j_from_mem), .dst_mem(dst_mem),
      .dst_flag_oh(dst_flag_oh), .gated(gated)
   );

   // code 7 in the flag view is F, so outsel indexes it directly (R6)
   assign flags8 = {f_q, flag_q};

   assign i_bit = i_from_nbr ? nbr_in[i_idx] : (i_from_mem ? rf_rd : flags8[i_idx]);
   assign j_bit = j_from_mem ? rf_rd : flags8[ctl.src_j];

   // R7: masked execution keyed on A
   assign cell_en = ~gated | flag_q[LOC_A];

   pe_alu #(.STYLE(ALU_STYLE)) u_alu (
      .func(ctl.func), .i_bit(i_bit), .j_bit(j_bit), .f_bit(f_q),
      .d_bit(alu_d), .f_nxt(alu_f)
   );

   pe_regfile #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .we(cell_en & dst_mem), .wdata(alu_d), .rdata(rf_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         f_q    <= 1'b0;
      end else if (cell_en) begin
         f_q <= alu_f;
         for (int g = 0; g < NUM_FLAGS; g++) begin
            if (dst_flag_oh[g]) flag_q[g] <= alu_d;
         end
      end
   end

   // R8: independent of cell_en
   assign nbr_out = flags8[ctl.outsel];

   p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_en |=> ($stable(flag_q) && $stable(f_q)));
   p_carry_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cell_en |=> (f_q == $past(alu_f)));
   p_disabled_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cell_en ##1 $stable(instr)) |-> $stable(nbr_out));
endmodule

// File: tb/pe_cell_bench.sv
module pe_cell_bench;
   localparam int NC      = 4;
   localparam int INSTR_W = 40;
   localparam logic [15:0] FN_HOLD = 16'h2277; // d=i, F kept
   localparam logic [15:0] FN_LOADF = 16'h00FF; // d=i, F=i
   localparam logic [15:0] FN_CLRF = 16'h0055;  // d=i, F=0
   localparam logic [15:0] FN_SETF = 16'hAAAA;  // d=0, F=1
   localparam logic [15:0] FN_ADC = 16'h166B;
   localparam logic [15:0] FN_ODD = 16'hC5A3;
   localparam logic [3:0] SI_N = 4'd0, SI_W = 4'd6, SI_X = 4'd8, SI_MEM = 4'd15;
   localparam logic [2:0] L_X = 3'd0, L_Y = 3'd1, L_Z = 3'd2, L_T = 3'd3,
                          L_A = 3'd6, L_M = 3'd7, O_F = 3'd7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [INSTR_W-1:0] instr;
   logic [7:0] nb_drv [NC];
   logic [NC-1:0] outs;
   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int         q_cyc [$];
   logic [3:0] q_exp [$];
   string      q_tag [$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   for (genvar c = 0; c < NC; c++) begin : g_arr
      logic [7:0] nin;
      if (c == 0) begin : g_edge
         assign nin = nb_drv[0];
      end else begin : g_link
         assign nin = {nb_drv[c][7], outs[c-1], nb_drv[c][5:0]};
      end
      if (c == 0) begin : g_u
         pe_cell u_pe_cell (.clk(clk), .rst_n(rst_n), .instr(instr),
                            .nbr_in(nin), .nbr_out(outs[c]));
      end else begin : g_o
         pe_cell u_cell (.clk(clk), .rst_n(rst_n), .instr(instr),
                         .nbr_in(nin), .nbr_out(outs[c]));
      end
   end

   // R10: field order of the instruction word
   function automatic logic [INSTR_W-1:0] mk(logic [15:0] fn, logic [2:0] cond,
      logic [3:0] si, logic [2:0] sj, logic [2:0] dst, logic [2:0] osel, logic [7:0] ad);
      return {fn, cond, si, sj, dst, osel, ad};
   endfunction

   function automatic logic [INSTR_W-1:0] nop(logic [2:0] osel);
      return mk(FN_HOLD, 3'd0, SI_X, L_X, L_X, osel, 8'd0);
   endfunction

   // drives one instruction; direction dir carries pat, other directions ~pat
   task automatic issue(input logic [INSTR_W-1:0] v, input int dir, input logic [3:0] pat,
                        input bit chk, input logic [3:0] exp, input string tag);
      @(posedge clk);
      #1;
      instr = v;
      for (int c = 0; c < NC; c++)
         for (int d = 0; d < 8; d++)
            if (!(c == 0 && d == 6)) nb_drv[c][d] = (d == dir) ? pat[c] : ~pat[c];
      if (chk) begin
         q_cyc.push_back(cyc);
         q_exp.push_back(exp);
         q_tag.push_back(tag);
      end
   endtask

   task automatic observe(input logic [2:0] osel, input logic [3:0] exp, input string tag);
      issue(nop(osel), 0, 4'h0, 1'b1, exp, tag);
   endtask

   task automatic read_mem(input logic [7:0] ad, input logic [3:0] exp, input string tag);
      issue(mk(FN_HOLD, 3'd0, SI_MEM, L_X, L_X, L_X, ad), 0, 4'h0, 1'b0, 4'h0, "");
      observe(L_X, exp, tag);
   endtask

   task automatic load(input logic [2:0] dst, input logic [7:0] ad, input logic [3:0] pat);
      issue(mk(FN_HOLD, 3'd0, SI_N, L_X, dst, L_X, ad), 0, pat, 1'b0, 4'h0, "");
   endtask

   // R3, R5: b += a in place per cell; a at 0..3, b at 4..7
   task automatic run_add(input logic [15:0] av, input logic [15:0] bv);
      logic [4:0] s [NC];
      logic [3:0] e;
      for (int c = 0; c < NC; c++) s[c] = {1'b0, av[4*c+:4]} + {1'b0, bv[4*c+:4]};
      for (int k = 0; k < 4; k++) begin
         for (int c = 0; c < NC; c++) e[c] = av[4*c+k];
         load(L_M, 8'(k), e);
         for (int c = 0; c < NC; c++) e[c] = bv[4*c+k];
         load(L_M, 8'(4+k), e);
      end
      issue(mk(FN_CLRF, 3'd0, SI_X, L_X, L_X, L_X, 8'd0), 0, 4'h0, 1'b0, 4'h0, "");
      for (int k = 0; k < 4; k++) begin
         issue(mk(FN_HOLD, 3'd0, SI_MEM, L_X, L_X, L_X, 8'(k)), 0, 4'h0, 1'b0, 4'h0, "");
         issue(mk(FN_ADC, 3'd0, SI_X, L_M, L_M, L_X, 8'(4+k)), 0, 4'h0, 1'b0, 4'h0, "");
      end
      for (int c = 0; c < NC; c++) e[c] = s[c][4];
      observe(O_F, e, "R3 carry out");
      for (int k = 0; k < 4; k++) begin
         for (int c = 0; c < NC; c++) e[c] = s[c][k];
         read_mem(8'(4+k), e, "R3 sum bit");
         for (int c = 0; c < NC; c++) e[c] = av[4*c+k];
         read_mem(8'(k), e, "R5 operand untouched");
      end
   endtask

   // R2: rows idx base..base+3, one per cell, through table FN_ODD
   task automatic run_rows(input int base);
      logic [3:0] pi, pj, pf, ed, ef;
      for (int c = 0; c < NC; c++) begin
         int idx;
         idx = base + c;
         pi[c] = idx[2]; pj[c] = idx[1]; pf[c] = idx[0];
         ef[c] = FN_ODD[15 - 2*idx];
         ed[c] = FN_ODD[14 - 2*idx];
      end
      load(L_X, 8'd0, pi);
      load(L_Y, 8'd0, pj);
      issue(mk(FN_LOADF, 3'd0, SI_N, L_X, L_T, L_X, 8'd0), 0, pf, 1'b0, 4'h0, "");
      observe(O_F, pf, "R9 carry loaded from table");
      issue(mk(FN_ODD, 3'd0, SI_X, L_Y, L_Z, L_X, 8'd0), 0, 4'h0, 1'b0, 4'h0, "");
      issue(nop(L_Z), 0, 4'h0, 1'b1, ed, "R2 data column");
      observe(O_F, ef, "R2 carry column");
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
         logic [3:0] ex;
         string tg;
         void'(q_cyc.pop_front());
         ex = q_exp.pop_front();
         tg = q_tag.pop_front();
         n_cmp++;
         if (outs !== ex) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tg, outs, ex, cyc);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [3:0] e;
      instr = nop(L_X);
      for (int c = 0; c < NC; c++) nb_drv[c] = 8'h00;
      nb_drv[0][6] = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int o = 0; o < 8; o++) observe(3'(o), 4'h0, "R1 flag after reset");
      read_mem(8'd0, 4'h0, "R1 register bit 0 after reset");
      read_mem(8'd255, 4'h0, "R1 register bit 255 after reset");

      // R4: every cell-driven neighbour direction into X
      for (int d = 0; d < 8; d++) begin
         if (d != 6) begin
            e = 4'(4'b0110 ^ d);
            issue(mk(FN_HOLD, 3'd0, 4'(d), L_X, L_X, L_X, 8'd0), d, e, 1'b0, 4'h0, "");
            observe(L_X, e, "R4 neighbour select");
         end
      end

      // R3, R5: multi-bit additions
      run_add(16'h08F3, 16'h0815);
      run_add(16'h697F, 16'hA79F);

      // R2: all eight rows
      run_rows(0);
      run_rows(4);

      // R7, R8: masked execution
      load(L_A, 8'd0, 4'b0101);
      load(L_Y, 8'd0, 4'b1111);
      load(L_T, 8'd0, 4'b1010);
      issue(mk(FN_CLRF, 3'd0, SI_X, L_X, L_X, L_X, 8'd0), 0, 4'h0, 1'b0, 4'h0, "");
      issue(mk(FN_SETF, 3'd1, SI_X, L_X, L_Y, L_T, 8'd0), 0, 4'h0, 1'b1, 4'b1010,
            "R8 outsel while masked");
      observe(L_Y, 4'b1010, "R7 masked data write");
      observe(O_F, 4'b0101, "R7 masked carry write");
      issue(mk(FN_HOLD, 3'd1, SI_N, L_X, L_M, L_X, 8'd100), 0, 4'b1111, 1'b0, 4'h0, "");
      read_mem(8'd100, 4'b0101, "R7 masked register write");
      load(L_X, 8'd0, 4'b1111);
      observe(L_X, 4'b1111, "R7 unconditional ignores A");

      // R6: forward F while reading west neighbour
      issue(mk(FN_LOADF, 3'd0, SI_N, L_X, L_T, L_X, 8'd0), 0, 4'b0110, 1'b0, 4'h0, "");
      issue(mk(FN_HOLD, 3'd0, SI_W, L_X, L_Y, O_F, 8'd0), 0, 4'h0, 1'b1, 4'b0110,
            "R6 forward F same cycle");
      observe(L_Y, 4'b1101, "R6 west neighbour captured");

      repeat (4) @(posedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule